// File: doc/BRIEF.md
# Link Integrity Warning Transmit Gater

This block sits between the link monitors of a two-port media converter and the enables of its two transmitters. While the warning feature is enabled, each port's transmitter follows the input link of the opposite port. If the opposite port's input link is down, the transmitter is switched off for a short window at the start of every long period. The remote partner on that side then sees its link indicator blink. If both input links are down, both transmitters stay off.

The feature needs two things. The warning strap must be set, and the device must be configured for a single data rate. In any other case both enables stay high, which is normal operation.

All timing derives from one shared millisecond prescaler of `CYC_PER_MS` clocks, which is 25000 at 25 MHz. A millisecond counter built on it wraps at the period length. The normal timebase is a 425 ms off window in a 3800 ms period. The fast-test timebase is a 104 ms off window in a 934 ms period. An active-low power-down/reset forces both enables low and clears the counters.

Top module: `liw_tx_gate`

## Requirements
- R1: While `rst_n` is 0, `tx_a_en` and `tx_b_en` are both 0. After release, the prescaler and the millisecond counter start from zero, so a link that is already down is gated from the start of an off window.
- R2: Unless both `warn_strap` and `one_speed` are 1, `tx_a_en` and `tx_b_en` are both 1 whatever the link inputs (all control inputs active high).
- R3: When the feature is active, a transmitter whose opposite port's link input is 1 at a clock edge has its enable at 1 after that edge. This includes an enable restored in the middle of an off window.
- R4: Normal timebase (`fast_test`=0), with port A's link down and port B's link up. Let the clock edge that first samples A's link at 0 be edge 0. After edge j, `tx_b_en` is 0 exactly when ((j / `CYC_PER_MS`) mod 3800) < 425, using integer division. `tx_a_en` stays 1 throughout.
- R5: Fast-test timebase (`fast_test`=1): the same rule as R4 holds with a period of 934 ms and an off window of 104 ms.
- R6: The gating is symmetric. Port B's link down with port A's link up gates `tx_a_en` by the same rule, and `tx_b_en` stays 1.
- R7: With the feature active and both link inputs 0, both enables are 0 one clock later and remain 0.
- R8: Any clock edge that samples a link input falling from 1 to 0 restarts the shared period, so a full off window begins at once, whatever the previous phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz clock |
| rst_n | input | 1 | Active-low power-down / reset |
| link_a_up | input | 1 | Port A input link is up |
| link_b_up | input | 1 | Port B input link is up |
| warn_strap | input | 1 | Link integrity warning enabled (strap) |
| one_speed | input | 1 | Device configured for a single data rate |
| fast_test | input | 1 | Selects the short test timebase |
| tx_a_en | output | 1 | Port A transmitter enable |
| tx_b_en | output | 1 | Port B transmitter enable |

## Verification
Each link input goes through one register. An enable therefore reacts on the first clock edge after a link change, and the bench changes inputs on falling edges and samples every enable on the falling edge after that. Configuration inputs and reset act on the enables combinationally, so they are checked on the falling edge just after they change. The gating windows are checked cycle by cycle, against j / `CYC_PER_MS` computed in the bench from the edge that sampled the drop. After a reset release the offset is one extra increment, because the counter already runs on the first edge. The bench uses a prescaler of 4 so that whole periods of both timebases are covered.

// File: rtl/liw_tx_gate.sv
module liw_tx_gate #(
  parameter int CYC_PER_MS  = 25000,
  parameter int PER_MS      = 3800,
  parameter int OFF_MS      = 425,
  parameter int FAST_PER_MS = 934,
  parameter int FAST_OFF_MS = 104
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_a_up,
  input  logic link_b_up,
  input  logic warn_strap,
  input  logic one_speed,
  input  logic fast_test,
  output logic tx_a_en,
  output logic tx_b_en
);
  localparam int MAXP = (PER_MS > FAST_PER_MS) ? PER_MS : FAST_PER_MS;
  localparam int PW   = $clog2(CYC_PER_MS + 1);
  localparam int MW   = $clog2(MAXP + 1);

  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic          a_q, b_q;

  wire active   = warn_strap & one_speed;
  wire drop     = (a_q & ~link_a_up) | (b_q & ~link_b_up);
  wire ms_tick  = (pre == PW'(CYC_PER_MS - 1));
  wire [MW-1:0] per_last = fast_test ? MW'(FAST_PER_MS - 1) : MW'(PER_MS - 1);
  wire [MW-1:0] off_lim  = fast_test ? MW'(FAST_OFF_MS) : MW'(OFF_MS);
  wire in_off   = ms < off_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ms  <= '0;
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= link_a_up;
      b_q <= link_b_up;
      if (drop) begin
        pre <= '0;
        ms  <= '0;
      end else if (ms_tick) begin
        pre <= '0;
        ms  <= (ms >= per_last) ? '0 : ms + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign tx_a_en = rst_n & (~active | b_q | (a_q & ~in_off));
  assign tx_b_en = rst_n & (~active | a_q | (b_q & ~in_off));
endmodule

module liw_tx_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic link_a_up,
  input logic link_b_up,
  input logic warn_strap,
  input logic one_speed,
  input logic tx_a_en,
  input logic tx_b_en
);
  always @(negedge clk)
    if (!rst_n) p_reset_off_r1: assert (!tx_a_en && !tx_b_en);

  p_inactive_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(warn_strap && one_speed) |-> (tx_a_en && tx_b_en));

  p_partner_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_strap && one_speed && link_a_up) ##1 (warn_strap && one_speed) |-> tx_b_en);

  p_partner_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_strap && one_speed && link_b_up) ##1 (warn_strap && one_speed) |-> tx_a_en);

  p_both_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_strap && one_speed && !link_a_up && !link_b_up) ##1 (warn_strap && one_speed)
    |-> (!tx_a_en && !tx_b_en));
endmodule

bind liw_tx_gate liw_tx_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_a_up(link_a_up), .link_b_up(link_b_up),
  .warn_strap(warn_strap), .one_speed(one_speed),
  .tx_a_en(tx_a_en), .tx_b_en(tx_b_en)
);

// File: tb/liw_tx_gate_bench.sv
module liw_tx_gate_bench;
  localparam int C = 4;
  logic clk = 0, rst_n = 0;
  logic link_a_up = 1, link_b_up = 1, warn_strap = 0, one_speed = 1, fast_test = 0;
  logic tx_a_en, tx_b_en;
  int runs = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  liw_tx_gate #(.CYC_PER_MS(C)) u_liw_tx_gate (
    .clk(clk), .rst_n(rst_n), .link_a_up(link_a_up), .link_b_up(link_b_up),
    .warn_strap(warn_strap), .one_speed(one_speed), .fast_test(fast_test),
    .tx_a_en(tx_a_en), .tx_b_en(tx_b_en));

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // chk_b=1: tx_b gated, tx_a held high; chk_b=0: the reverse
  task automatic sweep(input bit chk_b, input int per, input int offm, input int n,
                       input int ofs, input string req);
    int bad_g = 0, bad_o = 0;
    logic g = 0, o = 0, e = 0;
    for (int j = 0; j < n; j++) begin
      step();
      g = chk_b ? tx_b_en : tx_a_en;
      o = chk_b ? tx_a_en : tx_b_en;
      e = ((((j + ofs) / C) % per) >= offm);
      if (g !== e && bad_g == 0) begin
        bad_g = 1;
        $display("FAIL %s: gated enable got %b expected %b at step %0d", req, g, e, j);
      end
      if (o !== 1'b1 && bad_o == 0) begin
        bad_o = 1;
        $display("FAIL %s: other enable got %b expected 1 at step %0d", req, o, j);
      end
    end
    runs += 2;
    fails += bad_g + bad_o;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset tx_a", tx_a_en, 0);
    chk("R1 reset tx_b", tx_b_en, 0);
    rst_n = 1;
    // R2 strap off
    link_a_up = 0; warn_strap = 0; one_speed = 1;
    repeat (50) step();
    chk("R2 strap off tx_a", tx_a_en, 1);
    chk("R2 strap off tx_b", tx_b_en, 1);
    // R2 dual speed
    warn_strap = 1; one_speed = 0; link_b_up = 0;
    repeat (50) step();
    chk("R2 dual speed tx_a", tx_a_en, 1);
    chk("R2 dual speed tx_b", tx_b_en, 1);
    // R3 both up
    link_a_up = 1; link_b_up = 1; step();
    one_speed = 1; step();
    chk("R3 both up tx_a", tx_a_en, 1);
    chk("R3 both up tx_b", tx_b_en, 1);
    repeat (23) step();
    // R4 normal gating of tx_b
    link_a_up = 0;
    sweep(1, 3800, 425, 2 * 3800 * C + 1, 0, "R4 normal window");
    chk("R4 wrap into off", tx_b_en, 0);
    link_a_up = 1; step();
    chk("R3 restore mid window", tx_b_en, 1);
    repeat (37) step();
    // R5 / R6 fast gating of tx_a
    fast_test = 1; link_b_up = 0;
    sweep(0, 934, 104, 2 * 934 * C, 0, "R5 R6 fast window");
    link_b_up = 1; step();
    chk("R3 restore tx_a", tx_a_en, 1);
    // R8 restart at an arbitrary phase
    repeat (1001) step();
    link_a_up = 0;
    sweep(1, 934, 104, 104 * C + 9, 0, "R8 restart");
    // R7 both down
    link_b_up = 0;
    for (int k = 0; k < 600; k++) begin
      step();
      if (tx_a_en !== 0 || tx_b_en !== 0) begin
        chk("R7 both down", tx_a_en | tx_b_en, 0);
        break;
      end
      if (k == 599) chk("R7 both down", tx_a_en | tx_b_en, 0);
    end
    link_b_up = 1; step();
    repeat (200) step();
    // R1 mid-run reset clears timing
    rst_n = 0; @(negedge clk);
    chk("R1 mid reset tx_a", tx_a_en, 0);
    chk("R1 mid reset tx_b", tx_b_en, 0);
    rst_n = 1;
    sweep(1, 934, 104, 104 * C + 9, 1, "R1 counter cleared");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule